// File: doc/BRIEF.md
# Peripheral Reset and Clock Handshake Sequencer

This block puts a peripheral through a controlled reset by talking to a system controller. The controller takes separate write-one strobes for each action: raise reset, drop reset, stop clock and start clock. It reports two status levels back, one for reset and one for the clock. A single start pulse launches a fixed four-step handshake. Each step fires one strobe and then checks the matching status bit once per cycle until the bit reaches the level that step expects, or until the poll budget `POLL_MAX` is used up.

The steps run in this order. Step 1 raises reset and waits for reset status 1. Step 2 stops the clock and waits for clock status 0. Step 3 drops reset and waits for reset status 0. Step 4 starts the clock and waits for clock status 1. A timeout ends the run at once. The block then reports failure and the index of the step that timed out. Both status inputs are taken to be synchronous to `clk`.

The controller has four states. `ST_IDLE` moves to `ST_ISSUE` on start. `ST_ISSUE` fires the current step's strobe and always moves to `ST_POLL`. `ST_POLL` can take three exits. On a match it moves back to `ST_ISSUE` for the next step, or to `ST_FINISH` after step 4. When the budget runs out it moves to `ST_FINISH` with failure. Otherwise it stays in `ST_POLL`. `ST_FINISH` pulses done and returns to `ST_IDLE`.

Top module: `periph_rst_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, every strobe and fail_step_o (2'd0) are all low.
- R2: start_i high while idle fires rst_req_o in the very next cycle. That is the `ST_ISSUE` cycle of step 1.
- R3: The strobes fire in the fixed order rst_req_o, clk_off_o, rst_rel_o, clk_on_o. The levels awaited after each strobe are, in order: reset status 1, clock status 0, reset status 0, clock status 1.
- R4: Each strobe is high for exactly one cycle, and no two strobes are ever high together.
- R5: A step ends on the first poll cycle that sees the expected level. A step whose status matches on poll k therefore takes 1+k cycles: one issue cycle and k poll cycles.
- R6: If POLL_MAX consecutive polls all miss, the run aborts with no further strobes. fail_o is then 1 and fail_step_o gives the step that timed out (0 = step 1, 1 = step 2, 2 = step 3, 3 = step 4). No step ever polls more than POLL_MAX times.
- R7: done_o is a one-cycle pulse at the end of every run. fail_o is 0 after a run that succeeds. fail_o and fail_step_o keep their values until the next accepted start.
- R8: start_i is ignored while busy_o is high. It fires no strobe and does not change the run's length or result.
- R9: busy_o is high from the cycle after the accepted start through the done_o cycle. It is low again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| rst_stat_i | input | 1 | Reset status read back from the system controller |
| clk_stat_i | input | 1 | Clock status read back from the system controller |
| rst_req_o | output | 1 | One-cycle strobe: raise reset (step 1) |
| clk_off_o | output | 1 | One-cycle strobe: stop clock (step 2) |
| rst_rel_o | output | 1 | One-cycle strobe: drop reset (step 3) |
| clk_on_o | output | 1 | One-cycle strobe: start clock (step 4) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Last run timed out |
| fail_step_o | output | 2 | Index of the step that timed out |

## Verification
The hardest cases to reach are a late step timing out after the earlier steps have passed, and a match on the very last allowed poll. Either one needs the status inputs to answer each strobe after a chosen delay. The bench therefore contains a small model of the system controller that reacts to each strobe after a per-step latency. With a budget of four polls, it sweeps every combination of latencies 0 to 5 across all four steps. This covers passing on poll 1, passing on poll 4 and timing out in each step. On alternate runs it also raises a second start while the first run is still busy.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_POLL,
        ST_FINISH
    } seq_state_t;

    localparam int unsigned NUM_STEPS = 4;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    typedef logic [STEP_W-1:0] step_idx_t;
endpackage

// File: rtl/rcs_step_table.sv
module rcs_step_table
    import rcs_pkg::*;
(
    input  step_idx_t              step_i,
    output logic [NUM_STEPS-1:0]   strobe_sel_o,
    output logic                   watch_clk_o,
    output logic                   want_o
);
    // One strobe per step, in step order.
    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_sel
        assign strobe_sel_o[g] = (step_i == step_idx_t'(g));
    end

    // Which status bit each step watches, and the level it waits for.
    always_comb begin
        unique case (step_i)
            2'd0:    begin watch_clk_o = 1'b0; want_o = 1'b1; end
            2'd1:    begin watch_clk_o = 1'b1; want_o = 1'b0; end
            2'd2:    begin watch_clk_o = 1'b0; want_o = 1'b0; end
            default: begin watch_clk_o = 1'b1; want_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/rcs_poll_timer.sv
module rcs_poll_timer #(
    parameter int unsigned POLL_MAX = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic adv_i,
    output logic last_o
);
    localparam int unsigned CW = (POLL_MAX < 2) ? 1 : $clog2(POLL_MAX);

    logic [CW-1:0] cnt_q;

    // last_o is high during the final poll allowed by the budget.
    assign last_o = (cnt_q == CW'(POLL_MAX - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (adv_i && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/periph_rst_seq.sv
module periph_rst_seq
    import rcs_pkg::*;
#(
    parameter int unsigned POLL_MAX = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rst_stat_i,
    input  logic       clk_stat_i,
    output logic       rst_req_o,
    output logic       clk_off_o,
    output logic       rst_rel_o,
    output logic       clk_on_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       fail_o,
    output logic [1:0] fail_step_o
);
    localparam step_idx_t LAST_STEP = step_idx_t'(NUM_STEPS - 1);

    seq_state_t state_q, state_d;
    step_idx_t  step_q, step_d;
    logic       fail_q, fail_d;
    step_idx_t  fstep_q, fstep_d;

    logic [NUM_STEPS-1:0] sel;
    logic                 watch_clk;
    logic                 want;
    logic                 hit;
    logic                 last_poll;

    rcs_step_table u_table (
        .step_i       (step_q),
        .strobe_sel_o (sel),
        .watch_clk_o  (watch_clk),
        .want_o       (want)
    );

    rcs_poll_timer #(.POLL_MAX(POLL_MAX)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_ISSUE),
        .adv_i   (state_q == ST_POLL),
        .last_o  (last_poll)
    );

    assign hit = ((watch_clk ? clk_stat_i : rst_stat_i) == want);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            fail_q  <= 1'b0;
            fstep_q <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            fail_q  <= fail_d;
            fstep_q <= fstep_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        fail_d  = fail_q;
        fstep_d = fstep_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ISSUE;
                    step_d  = '0;
                    fail_d  = 1'b0;
                    fstep_d = '0;
                end
            end
            ST_ISSUE: state_d = ST_POLL;
            ST_POLL: begin
                if (hit) begin
                    if (step_q == LAST_STEP) begin
                        state_d = ST_FINISH;
                    end else begin
                        step_d  = step_q + 1'b1;
                        state_d = ST_ISSUE;
                    end
                end else if (last_poll) begin
                    fail_d  = 1'b1;
                    fstep_d = step_q;
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        logic [NUM_STEPS-1:0] stb;
        stb         = (state_q == ST_ISSUE) ? sel : '0;
        rst_req_o   = stb[0];
        clk_off_o   = stb[1];
        rst_rel_o   = stb[2];
        clk_on_o    = stb[3];
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_FINISH);
        fail_o      = fail_q;
        fail_step_o = fstep_q;
    end
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int unsigned POLL_MAX = 1000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       rst_req_o,
    input logic       clk_off_o,
    input logic       rst_rel_o,
    input logic       clk_on_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       fail_o,
    input logic [1:0] fail_step_o
);
    logic [3:0]  stb;
    logic [31:0] win_q;

    assign stb = {clk_on_o, rst_rel_o, clk_off_o, rst_req_o};

    // Cycles since the last strobe within a run.
    always_ff @(posedge clk) begin
        if (!rst_n)             win_q <= '0;
        else if (|stb)          win_q <= 32'd1;
        else if (busy_o)        win_q <= win_q + 32'd1;
        else                    win_q <= '0;
    end

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stb) <= 1);

    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|stb) |=> !(|stb));

    p_start_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> rst_req_o);

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !rst_req_o);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(fail_o) && $stable(fail_step_o)));

    p_poll_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (win_q <= POLL_MAX + 32'd1));

    p_no_strobe_after_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> !(|stb));
endmodule

bind periph_rst_seq rcs_checker #(.POLL_MAX(POLL_MAX)) u_rcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rst_req_o   (rst_req_o),
    .clk_off_o   (clk_off_o),
    .rst_rel_o   (rst_rel_o),
    .clk_on_o    (clk_on_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_step_o (fail_step_o)
);

// File: tb/tb_periph_rst_seq.sv
module tb_periph_rst_seq;
    localparam int TB_POLL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rs = 1'b0;
    logic       cs = 1'b1;
    logic       rst_req_o, clk_off_o, rst_rel_o, clk_on_o;
    logic       busy_o, done_o, fail_o;
    logic [1:0] fail_step_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    int dly [4];
    int rcnt = 0;
    int rkind = 0;
    int slog [8];
    int nlog = 0;
    int busy_cnt = 0;
    int done_cnt = 0;
    logic       fail_at_done = 1'b0;
    logic [1:0] step_at_done = 2'd0;
    logic       fail_now = 1'b0;
    logic [1:0] step_now = 2'd0;

    always #5 clk = ~clk;

    periph_rst_seq #(.POLL_MAX(TB_POLL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rst_stat_i(rs), .clk_stat_i(cs),
        .rst_req_o(rst_req_o), .clk_off_o(clk_off_o),
        .rst_rel_o(rst_rel_o), .clk_on_o(clk_on_o),
        .busy_o(busy_o), .done_o(done_o),
        .fail_o(fail_o), .fail_step_o(fail_step_o)
    );

    task automatic apply_kind(input int k);
        case (k)
            0: rs = 1'b1;
            1: cs = 1'b0;
            2: rs = 1'b0;
            default: cs = 1'b1;
        endcase
    endtask

    // System-controller model and monitor
    always @(negedge clk) begin
        int k;
        k = -1;
        if (rst_req_o) k = 0;
        else if (clk_off_o) k = 1;
        else if (rst_rel_o) k = 2;
        else if (clk_on_o) k = 3;
        if (k >= 0) begin
            if (nlog < 8) slog[nlog] = k;
            nlog++;
            rkind = k;
            if (dly[k] == 0) begin apply_kind(k); rcnt = 0; end
            else rcnt = dly[k];
        end else if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) apply_kind(rkind);
        end
        if (busy_o) busy_cnt++;
        if (done_o) begin
            done_cnt++;
            fail_at_done = fail_o;
            step_at_done = fail_step_o;
        end
        fail_now = fail_o;
        step_now = fail_step_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int a, input int b, input int c, input int d, input bit poke);
        int exp_busy, exp_steps, exp_fstep, p;
        bit exp_fail;
        int wait_n;
        @(posedge clk);
        rs = 1'b0; cs = 1'b1; rcnt = 0; nlog = 0; busy_cnt = 0; done_cnt = 0;
        dly[0] = a; dly[1] = b; dly[2] = c; dly[3] = d;
        // expected values
        exp_busy = 1; exp_steps = 0; exp_fail = 1'b0; exp_fstep = 0;
        for (int s = 0; s < 4; s++) begin
            p = (dly[s] < 1) ? 1 : dly[s];
            exp_steps++;
            if (p > TB_POLL) begin
                exp_busy += 1 + TB_POLL;
                exp_fail = 1'b1;
                exp_fstep = s;
                break;
            end
            exp_busy += 1 + p;
        end
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (poke) begin
            @(negedge clk); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        wait_n = 0;
        while (done_cnt == 0 && wait_n < 100) begin
            @(posedge clk);
            wait_n++;
        end
        @(negedge clk);
        @(posedge clk);
        check(done_cnt == 1, "R7 done pulse count", done_cnt, 1);
        check(busy_cnt == exp_busy, "R5/R9 busy cycles", busy_cnt, exp_busy);
        check(nlog == exp_steps, "R6/R8 strobe count", nlog, exp_steps);
        for (int i = 0; i < exp_steps && i < 8; i++)
            check(slog[i] == i, "R3 strobe order", slog[i], i);
        check(fail_at_done == exp_fail, "R6 fail flag", int'(fail_at_done), int'(exp_fail));
        if (exp_fail)
            check(int'(step_at_done) == exp_fstep, "R6 fail step", int'(step_at_done), exp_fstep);
        check(fail_now == exp_fail && (!exp_fail || int'(step_now) == exp_fstep),
              "R7 result held", int'(fail_now), int'(exp_fail));
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) dly[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !fail_o && fail_step_o == 2'd0 &&
              !rst_req_o && !clk_off_o && !rst_rel_o && !clk_on_o,
              "R1 reset state", int'(busy_o), 0);
        // R2 start issues step 1 in the next cycle
        @(posedge clk);
        dly[0] = 9; dly[1] = 0; dly[2] = 0; dly[3] = 0;
        rs = 1'b0; cs = 1'b1; rcnt = 0; nlog = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(rst_req_o && busy_o, "R2 step1 strobe after start", int'(rst_req_o), 1);
        @(negedge clk);
        check(!rst_req_o, "R4 strobe one cycle", int'(rst_req_o), 0);
        repeat (8) @(negedge clk);
        // sweep all latency combinations
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int c = 0; c < 6; c++)
                    for (int d = 0; d < 6; d++)
                        run_case(a, b, c, d, bit'((a + b + c + d) % 2));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule